// File: doc/BRIEF.md
# Logical Left Shifter With Flags

This execution unit shifts an operand to the left, filling with zeros, and writes the result back into a 32-bit general-register value. The operand is the low byte, the low half-word or the whole register, chosen by a size code. Only the bits that belong to the operand change; the rest of the register value passes through untouched. Alongside the result the unit produces carry, overflow, zero, negative and half-carry flags.

The shift count has three possible sources. It can be an immediate selector naming 1, 2, 4, 8 or 16. It can be an external 8-bit count operand. It can also be bits 15:8 of the register value being shifted, which is the case where the count byte sits inside the operand. A one-cycle start strobe launches an operation. One cycle later the unit presents the updated register value and the flags, together with a one-cycle done pulse. Fetch, decode and the register file sit around this block and are not part of it.

Top module: `shl_unit`

## Requirements
- R1: Size code 0 selects bits 7:0 as the operand, code 1 selects bits 15:0, and code 2 selects bits 31:0. After an operation, every bit of `reg_o` outside the operand equals the same bit of `reg_i`.
- R2: The immediate selector maps as follows: 0 is a count of 1, 1 is 2 and 2 is 4, all three legal for every size. Selector 3 is a count of 8 and is legal for sizes 1 and 2 only. Selector 4 is a count of 16 and is legal for size 2 only.
- R3: An illegal combination gives no done pulse and leaves every output holding its previous value. The illegal combinations are size code 3, source code 3, an immediate selector of 5 to 7, and an immediate count that the operand size does not allow.
- R4: Source code 0 takes the count from the immediate selector. Code 1 takes it from `cnt_ext_i`. Code 2 takes it from `reg_i[15:8]`, which is read before the shift. For both register sources only the low 5 bits of the byte are used.
- R5: `flag_c_o` is the last bit shifted out above the operand's top bit. It is 0 for a count of zero, and 0 for a count larger than the operand width. A count of zero leaves the operand unchanged.
- R6: `flag_v_o` and `flag_h_o` are 0 after every completed operation.
- R7: `flag_n_o` is the top bit of the sized result. `flag_z_o` is 1 exactly when the sized result is all zeros.
- R8: `done_o` goes high for exactly one cycle, in the cycle after a legal start. Outside that cycle, `reg_o` and the flags hold their values.
- R9: While reset is asserted, `reg_o`, `done_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle operation strobe |
| size_i | input | 2 | Operand size code (0 byte, 1 half-word, 2 word) |
| src_i | input | 2 | Count source (0 immediate, 1 external byte, 2 register bits 15:8) |
| imm_sel_i | input | 3 | Immediate count selector |
| cnt_ext_i | input | 8 | External count byte |
| reg_i | input | 32 | Register value to shift |
| reg_o | output | 32 | Updated register value |
| done_o | output | 1 | Result valid pulse |
| flag_c_o | output | 1 | Carry: last bit shifted out |
| flag_v_o | output | 1 | Overflow, always cleared |
| flag_z_o | output | 1 | Zero flag of the sized result |
| flag_n_o | output | 1 | Negative flag of the sized result |
| flag_h_o | output | 1 | Half-carry, always cleared |

## Verification
The bench targets four corner cases, and each one shows up at the outputs if the design gets it wrong.
- Counts equal to or larger than the operand width: a design that takes the carry from the wrong bit position reports a wrong `flag_c_o` here.
- A half-word shift whose count comes from its own upper byte: a design that reads the count after the shift, or that shields the count byte from the shift, produces the wrong result.
- Byte and half-word shifts: a design with a broken merge mask corrupts the upper bits of `reg_o`.
- Illegal immediate and size combinations: a design that executes them anyway raises `done_o` or changes `reg_o`.

Register counts with bits above bit 4 set, and a count of zero, catch a count that is not truncated to 5 bits and a stale carry.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 5;
  localparam int BYTE_W  = 8;
  localparam int HALF_W  = 16;
  localparam int WIDE_W  = 2 * REG_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SELF = 2'd2,
    SRC_BAD  = 2'd3
  } src_e;

  typedef struct packed {
    logic [REG_W-1:0] merged;
    logic             carry;
    logic             zero;
    logic             neg;
  } shl_res_t;

  // Operand mask for a size code.
  function automatic logic [REG_W-1:0] size_mask(size_e sz);
    case (sz)
      SZ_BYTE: size_mask = REG_W'((64'd1 << BYTE_W) - 1);
      SZ_HALF: size_mask = REG_W'((64'd1 << HALF_W) - 1);
      default: size_mask = '1;
    endcase
  endfunction

  // Operand width in bits for a size code.
  function automatic logic [CNT_W:0] size_bits(size_e sz);
    case (sz)
      SZ_BYTE: size_bits = (CNT_W+1)'(BYTE_W);
      SZ_HALF: size_bits = (CNT_W+1)'(HALF_W);
      default: size_bits = (CNT_W+1)'(REG_W);
    endcase
  endfunction

  // Shift the sized operand, merge it into the register, derive the flags.
  function automatic shl_res_t shl_eval(size_e sz, logic [CNT_W-1:0] cnt,
                                        logic [REG_W-1:0] r);
    logic [REG_W-1:0]  mask;
    logic [WIDE_W-1:0] wide;
    logic [CNT_W:0]    w;
    shl_res_t          o;
    mask     = size_mask(sz);
    w        = size_bits(sz);
    wide     = {{(WIDE_W-REG_W){1'b0}}, r & mask} << cnt;
    o.merged = (r & ~mask) | (wide[REG_W-1:0] & mask);
    o.carry  = wide[w];
    o.zero   = ((wide[REG_W-1:0] & mask) == '0);
    o.neg    = wide[w-1];
    return o;
  endfunction
endpackage

// File: rtl/shl_count_sel.sv
module shl_count_sel
  import shl_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [1:0]       src_i,
  input  logic [2:0]       imm_sel_i,
  input  logic [7:0]       cnt_ext_i,
  input  logic [7:0]       self_hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             legal_o
);
  logic             imm_ok;
  logic [CNT_W-1:0] imm_cnt;

  always_comb begin
    imm_cnt = '0;
    imm_ok  = 1'b0;
    case (imm_sel_i)
      3'd0: begin imm_cnt = CNT_W'(1);  imm_ok = 1'b1; end
      3'd1: begin imm_cnt = CNT_W'(2);  imm_ok = 1'b1; end
      3'd2: begin imm_cnt = CNT_W'(4);  imm_ok = 1'b1; end
      3'd3: begin imm_cnt = CNT_W'(8);  imm_ok = (size_i != SZ_BYTE); end
      3'd4: begin imm_cnt = CNT_W'(16); imm_ok = (size_i == SZ_WORD); end
      default: begin imm_cnt = '0; imm_ok = 1'b0; end
    endcase
  end

  always_comb begin
    cnt_o   = '0;
    legal_o = (size_i != SZ_BAD);
    case (src_i)
      SRC_IMM:  begin cnt_o = imm_cnt; legal_o = legal_o && imm_ok; end
      SRC_EXT:  cnt_o = cnt_ext_i[CNT_W-1:0];
      SRC_SELF: cnt_o = self_hi_i[CNT_W-1:0];
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shl_core.sv
module shl_core
  import shl_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [REG_W-1:0] reg_i,
  output logic [REG_W-1:0] res_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             neg_o
);
  shl_res_t r;

  always_comb begin
    r       = shl_eval(size_e'(size_i), cnt_i, reg_i);
    res_o   = r.merged;
    carry_o = r.carry;
    zero_o  = r.zero;
    neg_o   = r.neg;
  end

  // R5: a zero count must leave the register value untouched and clear the carry
  always_comb begin
    if (cnt_i == '0 && size_i != 2'd3) begin
      zero_cnt_chk: assert ((res_o == reg_i) && !carry_o);
    end
  end
endmodule

// File: rtl/shl_unit.sv
module shl_unit
  import shl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  src_i,
  input  logic [2:0]  imm_sel_i,
  input  logic [7:0]  cnt_ext_i,
  input  logic [31:0] reg_i,
  output logic [31:0] reg_o,
  output logic        done_o,
  output logic        flag_c_o,
  output logic        flag_v_o,
  output logic        flag_z_o,
  output logic        flag_n_o,
  output logic        flag_h_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             legal_w;
  logic             fire_w;
  logic [REG_W-1:0] res_w;
  logic             carry_w, zero_w, neg_w;
  logic [1:0]       size_q;

  shl_count_sel u_cnt (
    .size_i    (size_i),
    .src_i     (src_i),
    .imm_sel_i (imm_sel_i),
    .cnt_ext_i (cnt_ext_i),
    .self_hi_i (reg_i[15:8]),
    .cnt_o     (cnt_w),
    .legal_o   (legal_w)
  );

  shl_core u_core (
    .size_i  (size_i),
    .cnt_i   (cnt_w),
    .reg_i   (reg_i),
    .res_o   (res_w),
    .carry_o (carry_w),
    .zero_o  (zero_w),
    .neg_o   (neg_w)
  );

  assign fire_w = start_i && legal_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_o    <= '0;
      done_o   <= 1'b0;
      flag_c_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_n_o <= 1'b0;
      flag_h_o <= 1'b0;
      size_q   <= 2'd0;
    end else begin
      done_o <= fire_w;
      if (fire_w) begin
        reg_o    <= res_w;
        flag_c_o <= carry_w;
        flag_v_o <= 1'b0;
        flag_z_o <= zero_w;
        flag_n_o <= neg_w;
        flag_h_o <= 1'b0;
        size_q   <= size_i;
      end
    end
  end

  // R6
  vh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!flag_v_o && !flag_h_o));

  // R1
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && size_i == 2'd0) |=> (reg_o[31:8] == $past(reg_i[31:8])));

  // R1
  half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && size_i == 2'd1) |=> (reg_o[31:16] == $past(reg_i[31:16])));

  // R3
  illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !legal_w) |=> !done_o);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_w |=> ($stable(reg_o) && $stable(flag_c_o) && $stable(flag_z_o)));

  // R7
  neg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && size_q == 2'd0) |-> (flag_n_o == reg_o[7] && flag_z_o == (reg_o[7:0] == 8'd0)));

  // R7
  neg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && size_q == 2'd2) |-> (flag_n_o == reg_o[31] && flag_z_o == (reg_o == '0)));
endmodule

// File: tb/shl_unit_test.sv
module shl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [1:0]  src_i = 2'd0;
  logic [2:0]  imm_sel_i = 3'd0;
  logic [7:0]  cnt_ext_i = 8'd0;
  logic [31:0] reg_i = 32'd0;
  logic [31:0] reg_o;
  logic        done_o, flag_c_o, flag_v_o, flag_z_o, flag_n_o, flag_h_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  shl_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i), .src_i(src_i),
    .imm_sel_i(imm_sel_i), .cnt_ext_i(cnt_ext_i), .reg_i(reg_i), .reg_o(reg_o),
    .done_o(done_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o), .flag_z_o(flag_z_o),
    .flag_n_o(flag_n_o), .flag_h_o(flag_h_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  function automatic bit legal_of(logic [1:0] sz, logic [1:0] src, logic [2:0] sel);
    if (sz == 2'd3 || src == 2'd3) return 1'b0;
    if (src != 2'd0) return 1'b1;
    if (sel <= 3'd2) return 1'b1;
    if (sel == 3'd3) return sz != 2'd0;
    if (sel == 3'd4) return sz == 2'd2;
    return 1'b0;
  endfunction

  function automatic int count_of(logic [1:0] src, logic [2:0] sel, logic [7:0] ext,
                                  logic [31:0] r);
    if (src == 2'd0) return 1 << sel;
    if (src == 2'd1) return int'(ext % 8'd32);
    return int'(r[15:8] % 8'd32);
  endfunction

  // Bit-serial model: shift one place at a time, remembering the bit that drops off.
  task automatic model(input logic [1:0] sz, input int n, input logic [31:0] r,
                       output logic [31:0] res, output logic c, output logic z,
                       output logic neg);
    int w = width_of(sz);
    logic [31:0] op = 32'd0;
    for (int i = 0; i < w; i++) op[i] = r[i];
    c = 1'b0;
    for (int k = 0; k < n; k++) begin
      c = op[w-1];
      for (int i = w-1; i > 0; i--) op[i] = op[i-1];
      op[0] = 1'b0;
    end
    res = r;
    for (int i = 0; i < w; i++) res[i] = op[i];
    z = (op == 32'd0);
    neg = op[w-1];
  endtask

  task automatic run_op(logic [1:0] sz, logic [1:0] src, logic [2:0] sel,
                        logic [7:0] ext, logic [31:0] r);
    logic [31:0] er, prev;
    logic ec, ez, en, pc;
    bit ok = legal_of(sz, src, sel);
    prev = reg_o;
    pc = flag_c_o;
    if (ok) model(sz, count_of(src, sel, ext, r), r, er, ec, ez, en);
    @(negedge clk);
    size_i = sz; src_i = src; imm_sel_i = sel; cnt_ext_i = ext; reg_i = r;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    reg_i = ~r;
    chk("R8 done", 32'(done_o), 32'(ok));
    if (ok) begin
      chk("R1 R2 R4 result", reg_o, er);
      chk("R5 carry", 32'(flag_c_o), 32'(ec));
      chk("R7 zero", 32'(flag_z_o), 32'(ez));
      chk("R7 negative", 32'(flag_n_o), 32'(en));
      chk("R6 v/h", {30'd0, flag_v_o, flag_h_o}, 32'd0);
      prev = er;
      pc = ec;
    end else begin
      chk("R3 reg hold", reg_o, prev);
      chk("R3 carry hold", 32'(flag_c_o), 32'(pc));
    end
    @(negedge clk);
    chk("R8 single pulse", 32'(done_o), 32'd0);
    chk("R8 hold", reg_o, prev);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset reg", reg_o, 32'd0);
    chk("R9 reset flags", {26'd0, done_o, flag_c_o, flag_v_o, flag_z_o, flag_n_o, flag_h_o}, 32'd0);
    rst_n = 1'b1;
    // R5 R2: byte by 1 -> 0x4A, carry set
    run_op(2'd0, 2'd0, 3'd0, 8'd0, 32'hA5A5A5A5);
    chk("R1 byte by one", reg_o, 32'hA5A5A54A);
    // R4 count from own bits 15:8 (=5) on a byte
    run_op(2'd0, 2'd2, 3'd0, 8'd0, 32'hA5A505A5);
    chk("R4 byte self count", reg_o, 32'hA5A505A0);
    // R4 half-word whose count byte is inside the operand
    run_op(2'd1, 2'd2, 3'd0, 8'd0, 32'hA5A505A5);
    chk("R4 half self count", reg_o, 32'hA5A5B4A0);
    // R2 immediate 8 on a half-word, carry from bit 8
    run_op(2'd1, 2'd0, 3'd3, 8'd0, 32'hA5A5A5A5);
    chk("R5 half by eight carry", 32'(flag_c_o), 32'd1);
    // R2 immediate 16 on a word
    run_op(2'd2, 2'd0, 3'd4, 8'd0, 32'hA5A5A5A5);
    chk("R2 word by sixteen", reg_o, 32'hA5A50000);
    // R4 upper count bits ignored (0x25 -> 5)
    run_op(2'd2, 2'd1, 3'd0, 8'h25, 32'hA5A5A5A5);
    chk("R4 truncated count", reg_o, 32'hB4B4B4A0);
    // R5 count zero
    run_op(2'd2, 2'd1, 3'd0, 8'h00, 32'h80000001);
    chk("R5 zero count carry", 32'(flag_c_o), 32'd0);
    // R5 count equal to the width and beyond it
    run_op(2'd0, 2'd1, 3'd0, 8'd8, 32'h123456A5);
    chk("R5 byte by width", {reg_o[7:0], 7'd0, flag_c_o}, {8'h00, 7'd0, 1'b1});
    run_op(2'd0, 2'd1, 3'd0, 8'd20, 32'h123456A5);
    chk("R5 byte beyond width", {31'd0, flag_c_o}, 32'd0);
    // R3 illegal combinations
    run_op(2'd0, 2'd0, 3'd3, 8'd0, 32'h0F0F0F0F);
    run_op(2'd1, 2'd0, 3'd4, 8'd0, 32'h0F0F0F0F);
    run_op(2'd2, 2'd0, 3'd6, 8'd0, 32'h0F0F0F0F);
    run_op(2'd3, 2'd1, 3'd0, 8'd3, 32'h0F0F0F0F);
    run_op(2'd2, 2'd3, 3'd0, 8'd3, 32'h0F0F0F0F);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz  = 2'($urandom_range(0, 2));
      logic [1:0] src = 2'($urandom_range(0, 2));
      logic [2:0] sel = 3'($urandom_range(0, 4));
      if (($urandom % 16) == 0) sz = 2'd3;
      run_op(sz, src, sel, 8'($urandom), $urandom);
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule